// File: doc/BRIEF.md
# Store Forwarding Buffer with Address Verification

This block keeps stores in program order after they are issued and holds them there until they are declared safe. While a store is held it cannot reach the data cache. Safe stores are written out through a cache write port, oldest first, at most one per cycle. Every load that reads the data cache also searches the held stores in the same cycle. If a held store supplies all of the load's bytes, the load takes that store's data instead of the cache data.

The same-cycle search is kept short on purpose. It compares only the low `PW` bits of the word address and picks the youngest store that matches on those bits. One cycle later a verification stage repeats the search with the full address. It reports the correct decision and data, and it raises a replay flag whenever the fast decision cannot be trusted. That happens when the fast path forwarded wrongly, when it missed a store it should have used, or when the true matching store covers only part of the load's bytes. A flush input drops every store that has not yet been declared safe.

Top module: `store_fwd_buf`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready`=1, `cw_valid`=0 and `vf_valid`=0.
- R2: A store is accepted when `alloc_valid` and `alloc_ready` are both high. `alloc_ready` falls once `DEPTH` stores are held. A store offered while the buffer is full is dropped and never reaches the cache.
- R3: A pulse on `commit_valid` marks the oldest store that is not yet safe as safe. Only safe stores appear on the cache write port. `cw_valid` stays low while every held store is still unsafe.
- R4: Safe stores leave in program order, one per cycle in which `cw_ready` is high. While `cw_ready` is low the presented store holds steady. A store that has left the buffer no longer takes part in load searches.
- R5: In the cycle a load is presented, the block compares address bits [PW-1:0] against every held store and selects the youngest match. `ld_fwd` is 1 and `ld_fwd_data` carries that store's data exactly when the store's byte mask covers `ld_mask`, that is when `ld_mask & ~mask` is 0.
- R6: One cycle after `ld_valid`, `vf_valid` is 1. `vf_fwd` and `vf_data` then give the decision made from the youngest full-address match: forward only if its mask covers the load's bytes.
- R7: `vf_replay` is 1 when the fast path forwarded but the full check either disagrees or selects a different store.
- R8: `vf_replay` is 1 when the fast path did not forward but the full check finds a covering store.
- R9: `vf_replay` is 1 when the youngest full-address match covers only part of the load's bytes.
- R10: `flush` drops every store that is not yet safe. Safe stores stay and still drain. In the cycle of a flush, allocation and commit are ignored.
- R11: A commit pulse while no unsafe store is held has no effect on later stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Store offered |
| alloc_addr | input | AW | Store word address |
| alloc_data | input | DW | Store data |
| alloc_mask | input | DW/8 | Store byte enables |
| alloc_ready | output | 1 | A free entry exists |
| commit_valid | input | 1 | Mark oldest unsafe store safe |
| flush | input | 1 | Drop unsafe stores |
| cw_valid | output | 1 | Cache write request |
| cw_addr | output | AW | Cache write address |
| cw_data | output | DW | Cache write data |
| cw_mask | output | DW/8 | Cache write byte enables |
| cw_ready | input | 1 | Cache accepts the write |
| ld_valid | input | 1 | Load probe |
| ld_addr | input | AW | Load word address |
| ld_mask | input | DW/8 | Load byte enables |
| ld_fwd | output | 1 | Fast path forwards |
| ld_fwd_data | output | DW | Fast forwarded data |
| vf_valid | output | 1 | Verification result present |
| vf_fwd | output | 1 | Correct forwarding decision |
| vf_data | output | DW | Correct forwarded data |
| vf_replay | output | 1 | Load must re-execute |

## Verification
If the head pointer or the safe count is wrong, the cache write port shows it first: an address appears out of program order, or `cw_valid` rises for an unsafe store, on the first cycle `cw_ready` is high. If the occupancy count is wrong, the fast forwarding result in the probe cycle is wrong, because a store that has drained or been flushed still matches, or a live one is skipped. A mistake in the full-address comparison shows one cycle later as a wrong `vf_fwd` or a missing `vf_replay`. The load table is laid out so that partial-bit aliases separate the fast decision from the verified one.

// File: rtl/store_fwd_buf.sv
module store_fwd_buf #(
  parameter int DEPTH = 32,
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int PW    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc_valid,
  input  logic [AW-1:0]   alloc_addr,
  input  logic [DW-1:0]   alloc_data,
  input  logic [DW/8-1:0] alloc_mask,
  output logic            alloc_ready,
  input  logic            commit_valid,
  input  logic            flush,
  output logic            cw_valid,
  output logic [AW-1:0]   cw_addr,
  output logic [DW-1:0]   cw_data,
  output logic [DW/8-1:0] cw_mask,
  input  logic            cw_ready,
  input  logic            ld_valid,
  input  logic [AW-1:0]   ld_addr,
  input  logic [DW/8-1:0] ld_mask,
  output logic            ld_fwd,
  output logic [DW-1:0]   ld_fwd_data,
  output logic            vf_valid,
  output logic            vf_fwd,
  output logic [DW-1:0]   vf_data,
  output logic            vf_replay
);
  localparam int BW = DW / 8;
  localparam int IW = $clog2(DEPTH);
  localparam int CW = IW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [AW-1:0] s_addr [DEPTH];
  logic [DW-1:0] s_data [DEPTH];
  logic [BW-1:0] s_mask [DEPTH];

  logic [IW-1:0] head;
  logic [CW-1:0] cnt, ccnt;

  logic [IW-1:0] tail;
  logic drain, alloc_ok, commit_ok;

  assign tail        = head + cnt[IW-1:0];
  assign alloc_ready = cnt != FULL;
  assign cw_valid    = ccnt != '0;
  assign cw_addr     = s_addr[head];
  assign cw_data     = s_data[head];
  assign cw_mask     = s_mask[head];
  assign drain       = cw_valid && cw_ready;
  assign alloc_ok    = alloc_valid && alloc_ready && !flush;
  assign commit_ok   = commit_valid && (ccnt < cnt) && !flush;

  logic          p_hit, f_hit;
  logic [IW-1:0] p_idx, f_idx;

  always_comb begin
    p_hit = 1'b0;
    f_hit = 1'b0;
    p_idx = '0;
    f_idx = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (CW'(k) < cnt) begin
        if (s_addr[head + IW'(k)][PW-1:0] == ld_addr[PW-1:0]) begin
          p_hit = 1'b1;
          p_idx = head + IW'(k);
        end
        if (s_addr[head + IW'(k)] == ld_addr) begin
          f_hit = 1'b1;
          f_idx = head + IW'(k);
        end
      end
    end
  end

  logic p_cov, f_cov, true_fwd, replay_n;

  assign p_cov       = (ld_mask & ~s_mask[p_idx]) == '0;
  assign f_cov       = (ld_mask & ~s_mask[f_idx]) == '0;
  assign ld_fwd      = ld_valid && p_hit && p_cov;
  assign ld_fwd_data = s_data[p_idx];
  assign true_fwd    = f_hit && f_cov;
  assign replay_n    = ld_valid && ((ld_fwd != true_fwd) ||
                                    (ld_fwd && p_idx != f_idx) ||
                                    (f_hit && !f_cov));

  always_ff @(posedge clk) begin
    if (alloc_ok) begin
      s_addr[tail] <= alloc_addr;
      s_data[tail] <= alloc_data;
      s_mask[tail] <= alloc_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head      <= '0;
      cnt       <= '0;
      ccnt      <= '0;
      vf_valid  <= 1'b0;
      vf_fwd    <= 1'b0;
      vf_data   <= '0;
      vf_replay <= 1'b0;
    end else begin
      head <= head + IW'(drain);
      if (flush) cnt <= ccnt - CW'(drain);
      else       cnt <= cnt + CW'(alloc_ok) - CW'(drain);
      ccnt      <= ccnt + CW'(commit_ok) - CW'(drain);
      vf_valid  <= ld_valid;
      vf_fwd    <= ld_valid && true_fwd;
      vf_data   <= s_data[f_idx];
      vf_replay <= replay_n;
    end
  end
endmodule

// File: rtl/store_fwd_buf_check.sv
module store_fwd_buf_check #(
  parameter int DEPTH = 32,
  parameter int AW    = 16,
  parameter int DW    = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       alloc_valid,
  input logic                       alloc_ready,
  input logic                       flush,
  input logic                       cw_valid,
  input logic                       cw_ready,
  input logic [AW-1:0]              cw_addr,
  input logic [DW-1:0]              cw_data,
  input logic                       vf_valid,
  input logic                       vf_replay,
  input logic [$clog2(DEPTH):0]     cnt,
  input logic [$clog2(DEPTH):0]     ccnt
);
  localparam int CW = $clog2(DEPTH) + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);

  p_full_rejects_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid && !alloc_ready && !flush && !(cw_valid && cw_ready)
    |=> cnt == $past(cnt));

  p_safe_within_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ccnt <= cnt);

  p_write_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cw_valid && !cw_ready |=> cw_valid && $stable(cw_addr) && $stable(cw_data));

  p_flush_keeps_safe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> cnt == ccnt);

  p_replay_qualified_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vf_replay |-> vf_valid);
endmodule

bind store_fwd_buf store_fwd_buf_check #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) chk (
  .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
  .flush(flush), .cw_valid(cw_valid), .cw_ready(cw_ready), .cw_addr(cw_addr),
  .cw_data(cw_data), .vf_valid(vf_valid), .vf_replay(vf_replay),
  .cnt(cnt), .ccnt(ccnt)
);

// File: tb/store_fwd_buf_test.sv
`timescale 1ns/1ps
module store_fwd_buf_test;
  logic clk = 0, rst_n = 0;
  logic alloc_valid = 0, commit_valid = 0, flush = 0, cw_ready = 0, ld_valid = 0;
  logic [15:0] alloc_addr = 0, ld_addr = 0;
  logic [31:0] alloc_data = 0;
  logic [3:0]  alloc_mask = 0, ld_mask = 0;
  logic alloc_ready, cw_valid, ld_fwd, vf_valid, vf_fwd, vf_replay;
  logic [15:0] cw_addr;
  logic [31:0] cw_data, ld_fwd_data, vf_data;
  logic [3:0]  cw_mask;
  int errors = 0, checks = 0;
  bit done = 0;

  store_fwd_buf uut (.*);

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // row: op, addr, data, mask, fast fwd, fast data, vf fwd, vf data, replay
  localparam int NV = 18;
  localparam logic [119:0] TBL [NV] = '{
    {1'b0,16'h0013,32'hA0A0A0A0,4'hF,1'b0,32'h0,1'b0,32'h0,1'b0},
    {1'b0,16'h0105,32'h11111111,4'hF,1'b0,32'h0,1'b0,32'h0,1'b0},
    {1'b0,16'h0205,32'h22222222,4'hF,1'b0,32'h0,1'b0,32'h0,1'b0},
    {1'b0,16'h0013,32'h33333333,4'h3,1'b0,32'h0,1'b0,32'h0,1'b0},
    {1'b0,16'h0037,32'h44444444,4'hF,1'b0,32'h0,1'b0,32'h0,1'b0},
    {1'b0,16'h0037,32'h55555555,4'hF,1'b0,32'h0,1'b0,32'h0,1'b0},
    {1'b1,16'h0037,32'h0,4'hF,1'b1,32'h55555555,1'b1,32'h55555555,1'b0},
    {1'b1,16'h0205,32'h0,4'hF,1'b1,32'h22222222,1'b1,32'h22222222,1'b0},
    {1'b1,16'h0105,32'h0,4'hF,1'b1,32'h22222222,1'b1,32'h11111111,1'b1},
    {1'b1,16'h0013,32'h0,4'h3,1'b1,32'h33333333,1'b1,32'h33333333,1'b0},
    {1'b1,16'h0013,32'h0,4'hF,1'b0,32'h0,1'b0,32'h0,1'b1},
    {1'b1,16'h0999,32'h0,4'hF,1'b0,32'h0,1'b0,32'h0,1'b0},
    {1'b1,16'h0115,32'h0,4'hF,1'b1,32'h22222222,1'b0,32'h0,1'b1},
    {1'b1,16'h0413,32'h0,4'h1,1'b1,32'h33333333,1'b0,32'h0,1'b1},
    {1'b0,16'h0505,32'h66666666,4'h1,1'b0,32'h0,1'b0,32'h0,1'b0},
    {1'b1,16'h0205,32'h0,4'hF,1'b0,32'h0,1'b1,32'h22222222,1'b1},
    {1'b1,16'h0505,32'h0,4'h1,1'b1,32'h66666666,1'b1,32'h66666666,1'b0},
    {1'b1,16'h0999,32'h0,4'h2,1'b0,32'h0,1'b0,32'h0,1'b0}
  };

  task automatic do_alloc(input logic [15:0] a, input logic [31:0] d, input logic [3:0] m);
    @(negedge clk);
    alloc_valid = 1; alloc_addr = a; alloc_data = d; alloc_mask = m;
    @(negedge clk);
    alloc_valid = 0;
  endtask

  // R5 fast result in probe cycle; R6 R7 R8 R9 verified result one cycle later
  task automatic do_load(input logic [15:0] a, input logic [3:0] m, input bit ef,
                         input logic [31:0] ed, input bit vf, input logic [31:0] vd, input bit rp);
    @(negedge clk);
    ld_valid = 1; ld_addr = a; ld_mask = m;
    #1;
    chk(ld_fwd == ef, "R5 fast forward", 32'(ld_fwd), 32'(ef));
    if (ef) chk(ld_fwd_data == ed, "R5 fast data", ld_fwd_data, ed);
    @(negedge clk);
    ld_valid = 0;
    #1;
    chk(vf_valid == 1'b1, "R6 verify valid", 32'(vf_valid), 32'd1);
    chk(vf_fwd == vf, "R6 verify decision", 32'(vf_fwd), 32'(vf));
    if (vf) chk(vf_data == vd, "R6 verify data", vf_data, vd);
    chk(vf_replay == rp, "R7 R8 R9 replay", 32'(vf_replay), 32'(rp));
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got %h expected %h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(alloc_ready == 1, "R1 ready", 32'(alloc_ready), 32'd1);
    chk(cw_valid == 0, "R1 cw_valid", 32'(cw_valid), 32'd0);
    chk(vf_valid == 0, "R1 vf_valid", 32'(vf_valid), 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (TBL[i][119])
        do_load(TBL[i][118:103], TBL[i][70:67], TBL[i][66], TBL[i][65:34],
                TBL[i][33], TBL[i][32:1], TBL[i][0]);
      else
        do_alloc(TBL[i][118:103], TBL[i][102:71], TBL[i][70:67]);
    end

    // R3 R4: commit two, drain in order, stop at unsafe ones
    @(negedge clk); commit_valid = 1;
    repeat (2) @(negedge clk);
    commit_valid = 0;
    #1;
    chk(cw_valid && cw_addr == 16'h0013, "R3 head safe", 32'(cw_addr), 32'h0013);
    chk(cw_data == 32'hA0A0A0A0, "R3 head data", cw_data, 32'hA0A0A0A0);
    @(negedge clk); cw_ready = 1;
    @(negedge clk); #1;
    chk(cw_valid && cw_addr == 16'h0105, "R4 second drained", 32'(cw_addr), 32'h0105);
    @(negedge clk); #1;
    chk(cw_valid == 0, "R3 unsafe not written", 32'(cw_valid), 32'd0);
    cw_ready = 0;
    // R4: drained 0x0105 no longer matches
    do_load(16'h0105, 4'hF, 0, 0, 0, 0, 0);

    // R10: commit 0x0205, then flush the rest
    @(negedge clk); commit_valid = 1;
    @(negedge clk); commit_valid = 0; flush = 1;
    @(negedge clk); flush = 0;
    do_load(16'h0037, 4'hF, 0, 0, 0, 0, 0);
    do_load(16'h0205, 4'hF, 1, 32'h22222222, 1, 32'h22222222, 0);
    @(negedge clk); cw_ready = 1; #1;
    chk(cw_valid && cw_addr == 16'h0205, "R10 safe store drains", 32'(cw_addr), 32'h0205);
    @(negedge clk); #1;
    chk(cw_valid == 0, "R10 flushed not written", 32'(cw_valid), 32'd0);

    // R11: commit with nothing unsafe, later store stays unsafe
    @(negedge clk); commit_valid = 1;
    @(negedge clk); commit_valid = 0;
    do_alloc(16'h0777, 32'h77777777, 4'hF);
    #1;
    chk(cw_valid == 0, "R11 stray commit ignored", 32'(cw_valid), 32'd0);
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0; cw_ready = 0;

    // R2: fill, reject overflow
    for (int i = 0; i < 32; i++) do_alloc(16'h1000 + 16'(i), 32'(i), 4'hF);
    #1;
    chk(alloc_ready == 0, "R2 full", 32'(alloc_ready), 32'd0);
    do_alloc(16'h2000, 32'hFFFFFFFF, 4'hF);
    do_load(16'h2000, 4'hF, 1, 32'h10, 0, 0, 1);
    @(negedge clk); commit_valid = 1;
    repeat (33) @(negedge clk);
    commit_valid = 0; cw_ready = 1;
    for (int i = 0; i < 32; i++) begin
      #1;
      chk(cw_valid && cw_addr == 16'h1000 + 16'(i), "R4 drain order", 32'(cw_addr), 32'(16'h1000 + 16'(i)));
      @(negedge clk);
    end
    #1;
    chk(cw_valid == 0, "R2 overflow store dropped", 32'(cw_valid), 32'd0);
    chk(alloc_ready == 1, "R2 ready again", 32'(alloc_ready), 32'd1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule